// File: doc/BRIEF.md
# Byte-Interleaved 4:2:2 Stream Splitter with Embedded Sync Recovery

This block sits at the video input of an encoder and takes in a multiplexed 4:2:2 component stream that is captured on every rising clock edge. In narrow mode one 8-bit bus carries the components interleaved as blue difference, luma, red difference, luma. In wide mode a luma bus and a chroma bus arrive side by side, and the chroma bus alternates blue and red difference samples. The block sends each sample to its own output and pulses a valid strobe for every sample that belongs to active picture.

The block does not rely on external sync pins. It watches the luma bus for the embedded timing reference, an all-ones byte followed by two zero bytes and then a status byte. From each status byte it recovers the horizontal, vertical and field flags, and it drives them out with polarity that software can choose. It checks the protection bits of the status byte. A status byte that fails the check is rejected and its flags are never used. A good reference also resets the sample phase, so a byte that slips within a line can corrupt at most the rest of that line.

Top module: `vdx_demux`

## Requirements
- R1: While `rst` is high and on the cycle after it is released, all three valid strobes and `trs_err` are low, the internal H, V and F flags are 0, and each sync output therefore equals its polarity input.
- R2: With `wide_mode`=0 and active picture open, the bytes that follow a valid timing reference are assigned in the repeating order blue difference (`cb_out`), luma (`y_out`), red difference (`cr_out`), luma. Each byte pulses exactly one strobe. A byte captured at edge n appears on the outputs after edge n+4.
- R3: With `wide_mode`=1 and active picture open, `din_a` carries luma and pulses `y_vld` on every byte. `din_b` carries chroma and alternates `cb_vld` and `cr_vld`, beginning with blue difference on the first byte after a valid reference. The latency is the same as in R2.
- R4: A timing reference is the byte sequence FF, 00, 00 on `din_a` followed by a status byte. In the status byte, bit 7 is 1, bit 6 is F, bit 5 is V and bit 4 is H (1 marks end of active video, 0 marks start). Bits 3..0 are the protection bits: bit 3 = V^H, bit 2 = F^H, bit 1 = F^V, bit 0 = F^V^H.
- R5: A status byte that passes the check loads H, V and F. The new flags are visible after the edge that follows the edge at which the status byte was captured.
- R6: `h_out`, `v_out` and `f_out` equal the internal flag XOR `pol_h`, `pol_v` and `pol_f`. A change of polarity takes effect at once, without waiting for a clock edge.
- R7: A status byte whose bit 7 is 0, or whose protection bits do not match its F, V and H bits, raises `trs_err` for one cycle, with the same timing as R5. The flags, the active state and the sample phase all stay unchanged.
- R8: No strobe is raised for any of the four bytes of a timing reference, whether the status byte is good or bad. Active picture opens only on a good start code with V=0. It closes on a good end code or on a good start code with V=1. Outside active picture every strobe stays low.
- R9: Every good timing reference resets the sample phase, so the first active byte after it is blue difference. An extra or missing byte inside a line shifts the assignment only until the next reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock; all capture on rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wide_mode | input | 1 | 0: single interleaved bus; 1: split luma/chroma buses |
| pol_h | input | 1 | Inverts `h_out` when 1 |
| pol_v | input | 1 | Inverts `v_out` when 1 |
| pol_f | input | 1 | Inverts `f_out` when 1 |
| din_a | input | 8 | Interleaved stream (narrow) or luma bytes (wide); carries timing references |
| din_b | input | 8 | Chroma bytes in wide mode; ignored in narrow mode |
| y_out | output | 8 | Last luma sample |
| y_vld | output | 1 | One-cycle strobe for a new `y_out` |
| cb_out | output | 8 | Last blue difference sample |
| cb_vld | output | 1 | One-cycle strobe for a new `cb_out` |
| cr_out | output | 8 | Last red difference sample |
| cr_vld | output | 1 | One-cycle strobe for a new `cr_out` |
| h_out | output | 1 | Horizontal blanking flag after polarity |
| v_out | output | 1 | Vertical blanking flag after polarity |
| f_out | output | 1 | Field flag after polarity |
| trs_err | output | 1 | One-cycle pulse for a rejected status byte |

## Verification
The stimulus places corrupted status bytes both in front of a line and in the middle of an active line. A design that trusted them would open or close the picture at the wrong point or reset the phase. A design that let the bytes of the reference through would strobe FF or 00 as samples. Lines whose length is not a multiple of four test realignment: without the reset on each reference, the component assignment would stay rotated for the rest of the run. The stimulus also switches between narrow and wide mode during blanking, sends vertical-blanking lines and flips the polarity inputs. These catch a wrong chroma start in wide mode, strobes during V=1 lines, and polarity that is applied through a register.

// File: rtl/vdx_pkg.sv
package vdx_pkg;

    // preamble bytes plus the status byte
    localparam int TRS_LEN = 4;

    typedef struct packed {
        logic f;
        logic v;
        logic h;
    } tflags_t;

    typedef enum logic [1:0] {
        PH_CB = 2'd0,
        PH_YA = 2'd1,
        PH_CR = 2'd2,
        PH_YB = 2'd3
    } phase_e;

    // expected protection nibble for a given flag set
    function automatic logic [3:0] prot_bits(tflags_t t);
        return {t.v ^ t.h, t.f ^ t.h, t.f ^ t.v, t.f ^ t.v ^ t.h};
    endfunction

endpackage

// File: rtl/vdx_trs_scan.sv
module vdx_trs_scan #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = vdx_pkg::TRS_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] exit_a,
    output logic [DATA_W-1:0] exit_b,
    output logic [DATA_W-1:0] status,
    output logic              match
);
    localparam int NZERO = DEPTH - 2;

    logic [DEPTH-1:0][DATA_W-1:0] hist_a;
    logic [DEPTH-1:0][DATA_W-1:0] hist_b;
    logic [NZERO-1:0]             zero_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_a <= '0;
            hist_b <= '0;
        end else begin
            hist_a <= {hist_a[DEPTH-2:0], din_a};
            hist_b <= {hist_b[DEPTH-2:0], din_b};
        end
    end

    // the middle taps of the window must all be zero
    for (genvar g = 1; g <= NZERO; g++) begin : g_zero
        assign zero_hit[g-1] = (hist_a[g] == '0);
    end

    assign match  = (hist_a[DEPTH-1] == {DATA_W{1'b1}}) && (&zero_hit);
    assign status = hist_a[0];
    assign exit_a = hist_a[DEPTH-1];
    assign exit_b = hist_b[DEPTH-1];

endmodule

// File: rtl/vdx_sync_track.sv
module vdx_sync_track #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              match,
    input  logic [DATA_W-1:0] status,
    output vdx_pkg::tflags_t  flags,
    output logic              active,
    output logic              trs_err,
    output logic              accept
);
    import vdx_pkg::*;

    localparam int TOP = DATA_W - 1;

    tflags_t    code;
    logic [3:0] prot_rx;
    logic       code_ok;

    assign code    = tflags_t'({status[TOP-1], status[TOP-2], status[TOP-3]});
    assign prot_rx = status[TOP-4 -: 4];
    assign code_ok = status[TOP] && (prot_rx == prot_bits(code));
    assign accept  = match && code_ok;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags   <= '0;
            active  <= 1'b0;
            trs_err <= 1'b0;
        end else begin
            trs_err <= match && !code_ok;
            if (accept) begin
                flags  <= code;
                active <= !code.h && !code.v;
            end
        end
    end

    // R7
    reject_hold_chk: assert property (@(posedge clk) disable iff (rst)
        trs_err |-> ($stable(flags) && $stable(active)));

    // R8
    sav_open_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !code.h && !code.v) |=> active);

    // R5
    eav_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && code.h) |=> flags.h);

endmodule

// File: rtl/vdx_sample_route.sv
module vdx_sample_route #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = vdx_pkg::TRS_LEN
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              active,
    input  logic              match,
    input  logic              accept,
    input  logic [DATA_W-1:0] exit_a,
    input  logic [DATA_W-1:0] exit_b,
    output logic [DATA_W-1:0] y_out,
    output logic              y_vld,
    output logic [DATA_W-1:0] cb_out,
    output logic              cb_vld,
    output logic [DATA_W-1:0] cr_out,
    output logic              cr_vld
);
    import vdx_pkg::*;

    localparam int KW = $clog2(DEPTH);

    logic [KW-1:0] kill_cnt;
    phase_e        ph;
    logic          kill, emit, take_y, take_cb, take_cr;

    always_comb begin
        kill    = match || (kill_cnt != '0);
        emit    = active && !kill;
        take_y  = emit && (wide || ph[0]);
        take_cb = emit && (wide ? !ph[0] : (ph == PH_CB));
        take_cr = emit && (wide ?  ph[0] : (ph == PH_CR));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            kill_cnt <= '0;
            ph       <= PH_CB;
            y_vld    <= 1'b0;
            cb_vld   <= 1'b0;
            cr_vld   <= 1'b0;
            y_out    <= '0;
            cb_out   <= '0;
            cr_out   <= '0;
        end else begin
            if (match)
                kill_cnt <= KW'(DEPTH - 1);
            else if (kill_cnt != '0)
                kill_cnt <= kill_cnt - 1'b1;

            if (accept)
                ph <= PH_CB;
            else if (emit)
                ph <= phase_e'(ph + 2'd1);

            y_vld  <= take_y;
            cb_vld <= take_cb;
            cr_vld <= take_cr;
            if (take_y)  y_out  <= exit_a;
            if (take_cb) cb_out <= wide ? exit_b : exit_a;
            if (take_cr) cr_out <= wide ? exit_b : exit_a;
        end
    end

    // R8
    trs_mute_chk: assert property (@(posedge clk) disable iff (rst)
        match |=> !(y_vld || cb_vld || cr_vld));

    // R2
    narrow_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(wide) |-> $onehot0({y_vld, cb_vld, cr_vld}));

    // R3
    wide_pair_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(wide) && y_vld) |-> (cb_vld ^ cr_vld));

endmodule

// File: rtl/vdx_demux.sv
module vdx_demux #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wide_mode,
    input  logic              pol_h,
    input  logic              pol_v,
    input  logic              pol_f,
    input  logic [DATA_W-1:0] din_a,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] y_out,
    output logic              y_vld,
    output logic [DATA_W-1:0] cb_out,
    output logic              cb_vld,
    output logic [DATA_W-1:0] cr_out,
    output logic              cr_vld,
    output logic              h_out,
    output logic              v_out,
    output logic              f_out,
    output logic              trs_err
);
    import vdx_pkg::*;

    logic [DATA_W-1:0] exit_a, exit_b, status;
    logic              match, accept, active;
    tflags_t           flags;

    vdx_trs_scan #(.DATA_W(DATA_W), .DEPTH(TRS_LEN)) u_scan (
        .clk    (clk),
        .rst    (rst),
        .din_a  (din_a),
        .din_b  (din_b),
        .exit_a (exit_a),
        .exit_b (exit_b),
        .status (status),
        .match  (match)
    );

    vdx_sync_track #(.DATA_W(DATA_W)) u_track (
        .clk     (clk),
        .rst     (rst),
        .match   (match),
        .status  (status),
        .flags   (flags),
        .active  (active),
        .trs_err (trs_err),
        .accept  (accept)
    );

    vdx_sample_route #(.DATA_W(DATA_W), .DEPTH(TRS_LEN)) u_route (
        .clk    (clk),
        .rst    (rst),
        .wide   (wide_mode),
        .active (active),
        .match  (match),
        .accept (accept),
        .exit_a (exit_a),
        .exit_b (exit_b),
        .y_out  (y_out),
        .y_vld  (y_vld),
        .cb_out (cb_out),
        .cb_vld (cb_vld),
        .cr_out (cr_out),
        .cr_vld (cr_vld)
    );

    assign h_out = flags.h ^ pol_h;
    assign v_out = flags.v ^ pol_v;
    assign f_out = flags.f ^ pol_f;

endmodule

// File: tb/tb_vdx_demux.sv
module tb_vdx_demux;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wide_mode = 1'b0;
    logic       pol_h = 1'b0, pol_v = 1'b0, pol_f = 1'b0;
    logic [7:0] din_a = '0, din_b = '0;
    logic [7:0] y_out, cb_out, cr_out;
    logic       y_vld, cb_vld, cr_vld, h_out, v_out, f_out, trs_err;

    vdx_demux dut (
        .clk(clk), .rst(rst), .wide_mode(wide_mode),
        .pol_h(pol_h), .pol_v(pol_v), .pol_f(pol_f),
        .din_a(din_a), .din_b(din_b),
        .y_out(y_out), .y_vld(y_vld), .cb_out(cb_out), .cb_vld(cb_vld),
        .cr_out(cr_out), .cr_vld(cr_vld),
        .h_out(h_out), .v_out(v_out), .f_out(f_out), .trs_err(trs_err)
    );

    always #4 clk = ~clk;

    typedef struct packed {
        logic       w;
        logic       yv, cbv, crv;
        logic [7:0] y, cb, cr;
    } exps_t;

    int      n_vec = 0, n_bad = 0, k = 0;
    bit      done = 0;
    exps_t   exp_s [8];
    logic [3:0] exp_f [8];           // {f, v, h, err}
    logic    m_act = 0, m_f = 0, m_v = 0, m_h = 0;
    int      m_ph = 0;
    logic [2:0] pol_nx = 3'b000;     // {h, v, f}
    logic    wide_nx = 1'b0;

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_vec++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
        end
    endtask

    function automatic logic [3:0] prot(input logic f, v, h);
        return {v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    endfunction

    function automatic logic [7:0] rb();
        return 8'(1 + ($urandom % 254));
    endfunction

    // kind: 0 payload/blank byte, 1 preamble byte, 2 status byte
    task automatic step(input logic [7:0] a, input logic [7:0] b, input int kind);
        exps_t      e;
        logic [3:0] ef;
        logic       err, ok;
        string      tag;
        @(negedge clk);
        e   = exp_s[(k + 3) % 8];
        tag = e.w ? "R3 R8 R9" : "R2 R8 R9";
        check(tag, "y_vld",  y_vld,  e.yv);
        check(tag, "cb_vld", cb_vld, e.cbv);
        check(tag, "cr_vld", cr_vld, e.crv);
        if (e.yv)  check(tag, "y_out",  y_out,  e.y);
        if (e.cbv) check(tag, "cb_out", cb_out, e.cb);
        if (e.crv) check(tag, "cr_out", cr_out, e.cr);
        ef = exp_f[(k + 6) % 8];
        check("R4 R5 R6", "h_out", h_out, ef[1] ^ pol_h);
        check("R4 R5 R6", "v_out", v_out, ef[2] ^ pol_v);
        check("R4 R5 R6", "f_out", f_out, ef[3] ^ pol_f);
        check("R7", "trs_err", trs_err, ef[0]);
        {pol_h, pol_v, pol_f} = pol_nx;
        wide_mode = wide_nx;
        din_a = a;
        din_b = b;
        e   = '0;
        e.w = wide_mode;
        err = 1'b0;
        if (kind == 0 && m_act) begin
            if (wide_mode) begin
                e.yv = 1'b1; e.y = a;
                if (m_ph % 2 == 0) begin e.cbv = 1'b1; e.cb = b; end
                else               begin e.crv = 1'b1; e.cr = b; end
            end else begin
                case (m_ph)
                    0: begin e.cbv = 1'b1; e.cb = a; end
                    2: begin e.crv = 1'b1; e.cr = a; end
                    default: begin e.yv = 1'b1; e.y = a; end
                endcase
            end
            m_ph = (m_ph + 1) % 4;
        end
        if (kind == 2) begin
            ok = a[7] && (a[3:0] == prot(a[6], a[5], a[4]));
            if (ok) begin
                m_f = a[6]; m_v = a[5]; m_h = a[4];
                m_act = !a[4] && !a[5];
                m_ph = 0;
            end else begin
                err = 1'b1;
            end
        end
        exp_s[k % 8] = e;
        exp_f[k % 8] = {m_f, m_v, m_h, err};
        k++;
    endtask

    // bad: 0 clean, 1 flipped protection bit, 2 bit 7 cleared
    task automatic trs(input logic f, input logic v, input logic h, input int bad);
        logic [7:0] st;
        st = {1'b1, f, v, h, prot(f, v, h)};
        if (bad == 1) st[$urandom % 4] ^= 1'b1;
        if (bad == 2) st[7] = 1'b0;
        step(8'hFF, rb(), 1);
        step(8'h00, rb(), 1);
        step(8'h00, rb(), 1);
        step(st, rb(), 2);
    endtask

    task automatic payload(input int n);
        repeat (n) step(rb(), rb(), 0);
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) step((i % 2) ? 8'h10 : 8'h80, 8'h80, 0);
    endtask

    task automatic line(input int act_n, input int blank_n, input logic v, input logic f);
        trs(f, v, 1'b1, 0);
        blank(blank_n);
        trs(f, v, 1'b0, 0);
        payload(act_n);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL R1 watchdog: actual hung expected finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd4177));
        for (int i = 0; i < 8; i++) begin exp_s[i] = '0; exp_f[i] = '0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        check("R1", "strobes", {y_vld, cb_vld, cr_vld}, 3'b000);
        check("R1", "trs_err", trs_err, 1'b0);
        check("R1", "sync", {h_out, v_out, f_out}, 3'b000);

        // R2 plain narrow line
        line(16, 6, 1'b0, 1'b0);
        // R7 rejected start code ahead of a line keeps picture closed
        trs(1'b0, 1'b0, 1'b1, 0);
        blank(5);
        trs(1'b0, 1'b0, 1'b0, 1);
        payload(8);
        trs(1'b0, 1'b0, 1'b0, 0);
        payload(6);
        // R7 R8 rejected code inside active picture: muted, phase kept
        trs(1'b1, 1'b1, 1'b1, 1);
        payload(6);
        // R4 status with bit 7 clear
        trs(1'b0, 1'b1, 1'b0, 2);
        payload(5);
        // R9 slipped line then realigned line
        line(13, 6, 1'b0, 1'b0);
        line(12, 6, 1'b0, 1'b0);
        // R8 vertical blanking line
        line(12, 6, 1'b1, 1'b1);
        // R6 polarity changes
        pol_nx = 3'b101;
        line(8, 5, 1'b0, 1'b1);
        pol_nx = 3'b010;
        line(8, 5, 1'b1, 1'b0);
        pol_nx = 3'b000;
        // R3 wide mode
        trs(1'b0, 1'b0, 1'b1, 0);
        wide_nx = 1'b1;
        blank(6);
        trs(1'b0, 1'b0, 1'b0, 0);
        payload(10);
        line(9, 6, 1'b0, 1'b0);
        trs(1'b0, 1'b0, 1'b1, 0);
        wide_nx = 1'b0;
        blank(6);

        // random lines
        repeat (90) begin
            trs(1'($urandom % 2), 1'($urandom % 2), 1'b1, 0);
            if ($urandom % 4 == 0) wide_nx = ~wide_nx;
            if ($urandom % 5 == 0) pol_nx = 3'($urandom % 8);
            blank(4 + $urandom % 8);
            trs(1'($urandom % 2), 1'($urandom % 3 == 0),
                1'b0, ($urandom % 6 == 0) ? 1 + $urandom % 2 : 0);
            payload($urandom % 40);
            if ($urandom % 6 == 0) begin
                trs(1'($urandom % 2), 1'($urandom % 2), 1'($urandom % 2), 1);
                payload($urandom % 12);
            end
        end
        trs(1'b0, 1'b0, 1'b1, 0);
        blank(10);
        finish_run();
    end

endmodule